// File: doc/BRIEF.md
# Serial Configuration Stream Header Checker

This block sits on a one-bit-per-clock configuration stream and validates the framing that precedes the payload. Every 40-bit header has four parts. The first is a run of eight 1 bits that announces a stream. A 4-bit start code follows, then a 24-bit binary length and a 4-bit closing field. The block checks each part. It captures the declared length and counts stream bits from the first announcing 1 bit. When the count reaches the declared length, it raises `done` and stays there.

The declared length covers the 40 header bits, the payload and one extra bit for each device in the chain. The device count is the parameter `N_DEV`, and it sets the smallest length the block accepts. Every bit that belongs to a stream is passed to a registered serial output in arrival order. Leading idle zeros and anything after the end of the stream are not passed on.

Sticky flags report a broken announcing run, a wrong start code, a wrong closing field, a length too small to be legal, a stream that ends early and a 0 bit arriving after the declared end. The bits after the declared end are padding and are normally all 1s.

Top module: `cfg_hdr_chk`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_vld`, `done`, `hdr_ok`, every flag and `len_out` are 0.
- R2: A header is accepted only after it has been received in this exact sequence. The sequence starts with eight consecutive 1 bits. The start code 0010 follows, then a 24-bit length sent most significant bit first, then the closing code 1111. After the edge that samples the 40th header bit, `hdr_ok` is 1 and `len_out` holds the length.
- R3: While the block is searching for a stream, a 0 that follows one to seven 1 bits sets `err_pre` and restarts the search from zero ones. Zeros that arrive while no 1 has been seen are ignored and raise no flag.
- R4: The four bits after the eighth 1 are compared with 0010 once all four have arrived. On a mismatch, the block sets `err_sync` and returns to the search.
- R5: If the four bits after the length field are not 1111, the block sets `err_tail`, does not publish the length and returns to the search.
- R6: A length smaller than 40 + `N_DEV` (with `N_DEV` taken as at least 1) sets `err_len`, is not published and returns the block to the search.
- R7: `done` rises after the edge that samples the stream bit whose position equals the declared length. The first 1 of the announcing run is position 1. `done` then stays high until reset.
- R8: Every stream bit appears on `out_bit` with `out_vld` high one clock after it is sampled. This covers the announcing ones onward, up to and including the last counted bit. Search zeros, bits after `done` and bits after a halt are not forwarded.
- R9: 1 bits that arrive after `done` change no output and raise no flag.
- R10: A 0 bit that arrives after `done` sets `warn_trail`.
- R11: If `in_end` is high while a stream is in progress, `err_short` is set. A stream is in progress after at least one announcing 1, up to the last counted bit. The block then halts: until reset it forwards nothing, never raises `done` and raises no further flag.
- R12: Every flag stays set until reset. Once `hdr_ok` is 1, it stays 1 and `len_out` stays constant until reset.
- R13: A bit that arrives together with `in_end` is processed before `in_end` is judged. If that bit completes the stream, no `err_short` is raised. `in_end` while searching with no 1 seen, or after `done`, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_vld | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial stream bit |
| in_end | input | 1 | Marks the end of the incoming stream |
| out_vld | output | 1 | Forwarded bit strobe |
| out_bit | output | 1 | Forwarded stream bit |
| done | output | 1 | Declared length fully consumed |
| hdr_ok | output | 1 | A valid header has been accepted |
| len_out | output | LEN_W | Captured length |
| err_pre | output | 1 | Broken announcing run |
| err_sync | output | 1 | Wrong start code |
| err_tail | output | 1 | Wrong closing field |
| err_len | output | 1 | Declared length too small |
| err_short | output | 1 | Stream ended before the declared length |
| warn_trail | output | 1 | 0 bit seen after the declared end |

## Verification
The bench targets the off-by-one spots in the count. It uses the smallest legal length, which leaves a single payload bit, and it checks that `done` is still low one bit before the end. A design that counted from the start code, or compared against the length minus one, would raise `done` one bit early or late, or never.

It also covers an announcing run cut after five ones, a start code that differs only in its last bit and a closing field with a single 0. A design that checked fields bit by bit in the wrong place, or kept stale ones across a restart, would mis-flag these or go on to accept a later header.

Finally, it places the end marker on the very last counted bit, on an idle line and in the middle of the payload. A design that judged the end before processing the coinciding bit would flag a short stream that is in fact complete.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int PRE_W  = 8;
  localparam int SC_W   = 4;
  localparam int TAIL_W = 4;
  localparam int LFLD_W = 24;
  localparam int HDR_W  = PRE_W + SC_W + LFLD_W + TAIL_W;

  localparam logic [SC_W-1:0]   SYNC_CODE = 4'b0010;
  localparam logic [TAIL_W-1:0] TAIL_CODE = 4'b1111;

  localparam int F_PRE   = 0;
  localparam int F_SYNC  = 1;
  localparam int F_TAIL  = 2;
  localparam int F_LEN   = 3;
  localparam int F_SHORT = 4;
  localparam int F_TRAIL = 5;
  localparam int NFLAG   = 6;

  typedef enum logic [2:0] {
    ST_SRCH,
    ST_SYNC,
    ST_LEN,
    ST_TAIL,
    ST_DATA,
    ST_DONE,
    ST_HALT
  } seq_st_t;

endpackage

// File: rtl/cfg_hdr_seq.sv
module cfg_hdr_seq
  import cfg_hdr_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_bit,
  input  logic             in_end,
  input  logic             len_small,
  input  logic             len_hit,
  output seq_st_t          st,
  output logic             fwd,
  output logic             len_shift,
  output logic             len_cap,
  output logic             cnt_clr,
  output logic [NFLAG-1:0] ev
);

  localparam int PH_W = $clog2(LEN_W + 1);
  localparam int FLD_W = SC_W - 1;

  seq_st_t           st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [FLD_W-1:0]  fld_q, fld_d;
  logic              run_busy;

  assign st = st_q;

  // next state
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    fld_d     = fld_q;
    fwd       = 1'b0;
    len_shift = 1'b0;
    len_cap   = 1'b0;
    cnt_clr   = 1'b0;
    ev        = '0;
    if (in_vld) begin
      case (st_q)
        ST_SRCH: begin
          if (in_bit) begin
            fwd = 1'b1;
            if (ph_q == PH_W'(PRE_W - 1)) begin
              st_d = ST_SYNC;
              ph_d = '0;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end else begin
            if (ph_q != '0) ev[F_PRE] = 1'b1;
            ph_d    = '0;
            cnt_clr = 1'b1;
          end
        end
        ST_SYNC: begin
          fwd   = 1'b1;
          fld_d = {fld_q[FLD_W-2:0], in_bit};
          if (ph_q == PH_W'(SC_W - 1)) begin
            ph_d = '0;
            if ({fld_q, in_bit} == SYNC_CODE) begin
              st_d = ST_LEN;
            end else begin
              ev[F_SYNC] = 1'b1;
              st_d       = ST_SRCH;
              cnt_clr    = 1'b1;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_LEN: begin
          fwd       = 1'b1;
          len_shift = 1'b1;
          if (ph_q == PH_W'(LEN_W - 1)) begin
            ph_d = '0;
            st_d = ST_TAIL;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_TAIL: begin
          fwd   = 1'b1;
          fld_d = {fld_q[FLD_W-2:0], in_bit};
          if (ph_q == PH_W'(TAIL_W - 1)) begin
            ph_d = '0;
            if ({fld_q, in_bit} != TAIL_CODE) begin
              ev[F_TAIL] = 1'b1;
              st_d       = ST_SRCH;
              cnt_clr    = 1'b1;
            end else if (len_small) begin
              ev[F_LEN] = 1'b1;
              st_d      = ST_SRCH;
              cnt_clr   = 1'b1;
            end else begin
              len_cap = 1'b1;
              st_d    = ST_DATA;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_DATA: begin
          fwd = 1'b1;
          if (len_hit) st_d = ST_DONE;
        end
        ST_DONE: begin
          if (!in_bit) ev[F_TRAIL] = 1'b1;
        end
        default: ;
      endcase
    end
    run_busy = (st_d == ST_SYNC) || (st_d == ST_LEN) || (st_d == ST_TAIL) ||
               (st_d == ST_DATA) || ((st_d == ST_SRCH) && (ph_d != '0));
    if (in_end && run_busy) begin
      ev[F_SHORT] = 1'b1;
      st_d        = ST_HALT;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SRCH;
      ph_q  <= '0;
      fld_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      fld_q <= fld_d;
    end
  end

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_DONE));

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |=> (st_q == ST_HALT));

  p_pre_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_bit && (st_q == ST_SRCH)) |=> ((st_q == ST_SRCH) && (ph_q == '0)));

  p_one_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev[F_PRE], ev[F_SYNC], ev[F_TAIL], ev[F_LEN]}));

endmodule

// File: rtl/cfg_hdr_len.sv
module cfg_hdr_len
  import cfg_hdr_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int N_DEV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             cap_en,
  input  logic             cnt_inc,
  input  logic             cnt_clr,
  output logic [LEN_W-1:0] len_q,
  output logic             hdr_ok,
  output logic             len_small,
  output logic             len_hit
);

  localparam int N_DEV_EFF = (N_DEV < 1) ? 1 : N_DEV;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(HDR_W + N_DEV_EFF);

  logic [LEN_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_d;
  logic             ok_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    len_d = len_q;
    ok_d  = hdr_ok;
    if (shift_en) sh_d = {sh_q[LEN_W-2:0], bit_in};
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (cnt_inc) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (cap_en) begin
      len_d = sh_q;
      ok_d  = 1'b1;
    end
  end

  assign len_small = (sh_q < MIN_LEN);
  assign len_hit   = ((cnt_q + 1'b1) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      hdr_ok <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      hdr_ok <= ok_d;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |-> (cnt_q <= len_q));

  p_len_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |=> (hdr_ok && $stable(len_q)));

endmodule

// File: rtl/cfg_hdr_flags.sv
module cfg_hdr_flags #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] ev,
  output logic [NF-1:0] flg
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_d;

    always_comb begin
      f_d = flg[i];
      if (ev[i]) f_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg[i] <= 1'b0;
      else        flg[i] <= f_d;
    end

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flg[i] |=> flg[i]);
  end

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
  import cfg_hdr_pkg::*;
#(
  parameter int LEN_W = LFLD_W,
  parameter int N_DEV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_bit,
  input  logic             in_end,
  output logic             out_vld,
  output logic             out_bit,
  output logic             done,
  output logic             hdr_ok,
  output logic [LEN_W-1:0] len_out,
  output logic             err_pre,
  output logic             err_sync,
  output logic             err_tail,
  output logic             err_len,
  output logic             err_short,
  output logic             warn_trail
);

  seq_st_t          st;
  logic             fwd, len_shift, len_cap, cnt_clr;
  logic             len_small, len_hit;
  logic [NFLAG-1:0] ev, flg;
  logic             ov_d, ob_d;

  cfg_hdr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_bit    (in_bit),
    .in_end    (in_end),
    .len_small (len_small),
    .len_hit   (len_hit),
    .st        (st),
    .fwd       (fwd),
    .len_shift (len_shift),
    .len_cap   (len_cap),
    .cnt_clr   (cnt_clr),
    .ev        (ev)
  );

  cfg_hdr_len #(.LEN_W(LEN_W), .N_DEV(N_DEV)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (len_shift),
    .bit_in    (in_bit),
    .cap_en    (len_cap),
    .cnt_inc   (fwd),
    .cnt_clr   (cnt_clr),
    .len_q     (len_out),
    .hdr_ok    (hdr_ok),
    .len_small (len_small),
    .len_hit   (len_hit)
  );

  cfg_hdr_flags #(.NF(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .flg   (flg)
  );

  assign err_pre    = flg[F_PRE];
  assign err_sync   = flg[F_SYNC];
  assign err_tail   = flg[F_TAIL];
  assign err_len    = flg[F_LEN];
  assign err_short  = flg[F_SHORT];
  assign warn_trail = flg[F_TRAIL];
  assign done       = (st == ST_DONE);

  // output stage
  always_comb begin
    ov_d = fwd;
    ob_d = out_bit;
    if (fwd) ob_d = in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= ov_d;
      out_bit <= ob_d;
    end
  end

  p_fwd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  p_done_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hdr_ok);

endmodule

// File: tb/cfg_hdr_chk_tb_top.sv
`timescale 1ns/1ps
module cfg_hdr_chk_tb_top;

  localparam int LW = 24;
  localparam int ND = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0, in_bit = 1'b0, in_end = 1'b0;
  logic          out_vld, out_bit, done, hdr_ok;
  logic [LW-1:0] len_out;
  logic          err_pre, err_sync, err_tail, err_len, err_short, warn_trail;

  always #4 clk = ~clk;

  cfg_hdr_chk #(.LEN_W(LW), .N_DEV(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bit(in_bit), .in_end(in_end),
    .out_vld(out_vld), .out_bit(out_bit), .done(done), .hdr_ok(hdr_ok),
    .len_out(len_out), .err_pre(err_pre), .err_sync(err_sync), .err_tail(err_tail),
    .err_len(err_len), .err_short(err_short), .warn_trail(warn_trail)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 search, 1 header, 2 payload, 3 done, 4 halted
  int          m_mode, m_pos, m_len;
  logic [39:0] m_hdr;
  bit          m_fwd, m_fb, m_hok;
  bit          e_pre, e_sync, e_tail, e_len, e_short, e_trail;

  task automatic m_restart();
    m_mode = 0;
    m_pos  = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_restart();
      m_hdr = '0; m_len = 0; m_fwd = 0; m_fb = 0; m_hok = 0;
      e_pre = 0; e_sync = 0; e_tail = 0; e_len = 0; e_short = 0; e_trail = 0;
    end else begin
      m_fwd = 0;
      if (in_vld) begin
        case (m_mode)
          0: if (in_bit) begin
               m_fwd = 1; m_pos++;
               if (m_pos == 8) m_mode = 1;
             end else begin
               if (m_pos > 0) e_pre = 1;
               m_pos = 0;
             end
          1: begin
               m_fwd = 1; m_pos++;
               m_hdr = {m_hdr[38:0], in_bit};
               if (m_pos == 12 && m_hdr[3:0] != 4'b0010) begin
                 e_sync = 1; m_restart();
               end else if (m_pos == 40) begin
                 if (m_hdr[3:0] != 4'hF) begin
                   e_tail = 1; m_restart();
                 end else if (int'(m_hdr[27:4]) < 40 + ND) begin
                   e_len = 1; m_restart();
                 end else begin
                   m_len = int'(m_hdr[27:4]); m_hok = 1; m_mode = 2;
                 end
               end
             end
          2: begin
               m_fwd = 1; m_pos++;
               if (m_pos == m_len) m_mode = 3;
             end
          3: if (!in_bit) e_trail = 1;
          default: ;
        endcase
        if (m_fwd) m_fb = in_bit;
      end
      if (in_end && ((m_mode == 0 && m_pos > 0) || m_mode == 1 || m_mode == 2)) begin
        e_short = 1; m_mode = 4;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 out_vld", out_vld, m_fwd);
      if (m_fwd) check("R8 out_bit", out_bit, m_fb);
      check("R7 done", done, m_mode == 3);
      check("R2 hdr_ok", hdr_ok, m_hok);
      check("R12 len_out", len_out, m_len);
      check("R3 err_pre", err_pre, e_pre);
      check("R4 err_sync", err_sync, e_sync);
      check("R5 err_tail", err_tail, e_tail);
      check("R6 err_len", err_len, e_len);
      check("R11 err_short", err_short, e_short);
      check("R10 warn_trail", warn_trail, e_trail);
    end
  end

  task automatic drive(input logic v, input logic b, input logic e);
    @(negedge clk);
    in_vld = v; in_bit = b; in_end = e;
  endtask

  task automatic settle();
    drive(0, 0, 0);
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) drive(1, w[i], 0);
  endtask

  task automatic send_hdr(input logic [23:0] len, input logic [3:0] sc, input logic [3:0] tl);
    send_word(32'hFF, 8);
    send_word({28'd0, sc}, 4);
    send_word({8'd0, len}, 24);
    send_word({28'd0, tl}, 4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_vld = 0; in_bit = 0; in_end = 0;
    @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset out_vld", out_vld, 0);
    check("R1 reset hdr_ok", hdr_ok, 0);
    check("R1 reset len_out", len_out, 0);
    check("R1 reset flags", {err_pre, err_sync, err_tail, err_len, err_short, warn_trail}, 0);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_err++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    settle();
    check("R1 after release", {done, hdr_ok, out_vld}, 0);

    // S1: idle zeros, idle end, good stream of 60, pads, trailing zero
    repeat (3) drive(1, 0, 0);
    drive(0, 0, 1);
    settle();
    check("R3 idle zeros no flag", err_pre, 0);
    check("R13 idle end no flag", err_short, 0);
    send_hdr(24'd60, 4'b0010, 4'b1111);
    settle();
    check("R2 hdr accepted", hdr_ok, 1);
    check("R2 length", len_out, 60);
    for (int i = 0; i < 19; i++) drive(1, (i % 3) == 1, 0);
    settle();
    check("R7 not early", done, 0);
    drive(1, 1, 0);
    settle();
    check("R7 done at length", done, 1);
    repeat (10) drive(1, 1, 0);
    settle();
    check("R9 pads absorbed", warn_trail, 0);
    check("R9 pads no forward", out_vld, 0);
    drive(1, 0, 0);
    settle();
    check("R10 trailing zero", warn_trail, 1);
    drive(0, 0, 1);
    settle();
    check("R13 end after done", err_short, 0);

    // S2: cut announcing run, then stream ending with in_end on final bit
    do_reset();
    repeat (5) drive(1, 1, 0);
    drive(1, 0, 0);
    settle();
    check("R3 broken run", err_pre, 1);
    send_hdr(24'd45, 4'b0010, 4'b1111);
    repeat (4) drive(1, 0, 0);
    drive(1, 1, 1);
    settle();
    check("R13 final bit with end", err_short, 0);
    check("R13 done", done, 1);
    check("R12 pre flag held", err_pre, 1);

    // S3: start code, tail and length errors
    do_reset();
    send_word(32'hFF, 8);
    send_word(32'b0011, 4);
    settle();
    check("R4 bad start code", err_sync, 1);
    send_hdr(24'd50, 4'b0010, 4'b1101);
    settle();
    check("R5 bad tail", err_tail, 1);
    check("R5 no publish", hdr_ok, 0);
    send_hdr(24'd40, 4'b0010, 4'b1111);
    settle();
    check("R6 short length", err_len, 1);
    check("R6 no publish", hdr_ok, 0);
    check("R3 no spurious", err_pre, 0);

    // S4: early end halts
    do_reset();
    send_hdr(24'd50, 4'b0010, 4'b1111);
    send_word(32'b101, 3);
    drive(0, 0, 1);
    settle();
    check("R11 short flag", err_short, 1);
    repeat (12) drive(1, 0, 0);
    settle();
    check("R11 halted no done", done, 0);
    check("R11 halted no warn", warn_trail, 0);
    check("R12 len held", len_out, 50);

    // S5: minimum legal length
    do_reset();
    send_hdr(24'd41, 4'b0010, 4'b1111);
    settle();
    check("R7 min length not done", done, 0);
    drive(1, 0, 0);
    settle();
    check("R7 min length done", done, 1);
    check("R6 min accepted", err_len, 0);
    repeat (3) settle();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule